// File: doc/BRIEF.md
# Early Answer-to-Reset Detector

This block watches a smart card's I/O line while the card is held in reset and just after it is released. It catches a card that starts its answer-to-reset too soon. It counts card clock pulses from the most recent edge of the card reset pin. When the first start bit appears on I/O, the block compares the count with a forbidden window for the current reset level. A start bit is a high-to-low transition of the I/O line after a two-stage synchronizer.

The window depends on the reset level. While reset is low, activity during the first `IGN` pulses is ignored, and a start bit at any later pulse count below `NMAX` is early. While reset is high, any start bit before `NMAX` pulses is early. Each edge of the reset pin clears the counter and the flag, and re-arms the detector. An early answer gives a one-cycle pulse and sets a flag. The flag stays set until the next reset edge.

Top module: `early_answer_detect`

## Requirements
- R1: While `rst_n` is low and right after it is released, `ea_pulse` and `ea_flag` are 0.
- R2: With `card_rst` low, a start bit seen at a pulse count below `IGN` gives no pulse. It is not counted as the first start bit, so a later start bit in the window is still judged.
- R3: With `card_rst` low, a first start bit at a pulse count from `IGN` up to `NMAX`-1 gives an early answer.
- R4: With `card_rst` high, a first start bit at a pulse count from 0 up to `NMAX`-1 gives an early answer.
- R5: A start bit at a pulse count of `NMAX` or more is never early, in either phase. The count stops at `NMAX` and does not wrap, however many pulses follow.
- R6: Only the first start bit that is judged after a reset edge counts. Later start bits give no pulse until the next reset edge.
- R7: Any change of level on `card_rst` sets the pulse count to 0, clears `ea_flag` on the next cycle, and re-arms the detector.
- R8: `ea_pulse` is high for exactly one cycle for each early answer. `ea_flag` goes high together with it and stays high until the next reset edge.
- R9: Suppose `io_line` falls while setup is met before a rising clock edge. Then `ea_pulse` rises on the third rising edge from that point, and not before. A rising edge of `io_line` never causes a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_tick | input | 1 | One-cycle strobe per card clock pulse |
| card_rst | input | 1 | Card reset pin level, already synchronous to `clk` |
| io_line | input | 1 | Raw card I/O line, idles high |
| ea_pulse | output | 1 | One-cycle pulse on an early answer |
| ea_flag | output | 1 | Sticky early-answer flag, cleared by a reset edge |

## Verification
A counter that does not clear on a reset edge, or that wraps, shifts the window. A sweep of pulse counts across both phases then shows a pulse at the wrong count, three cycles after the start bit is driven. A detector that never drops its armed state shows up on the next start bit, as a second pulse. A wrong ignore decision shows up too: a start bit in the low-phase ignore period wrongly blocks a later start bit in the window. A flag that does not clear is visible one cycle after the reset edge.

// File: rtl/ead_pkg.sv
package ead_pkg;

  typedef enum logic [1:0] {
    V_IGNORE = 2'd0,
    V_EARLY  = 2'd1,
    V_LATE   = 2'd2
  } verdict_t;

  // Judge a start bit from the reset phase and the pulse count.
  function automatic verdict_t ead_verdict(input logic phase_hi,
                                           input int unsigned cnt,
                                           input int unsigned ign,
                                           input int unsigned nmax);
    if (!phase_hi && cnt < ign) return V_IGNORE;
    if (cnt < nmax)             return V_EARLY;
    return V_LATE;
  endfunction

endpackage

// File: rtl/ead_sync.sv
module ead_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], line_in};
  end

  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  assign line_fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/ead_phase_cnt.sv
module ead_phase_cnt #(
  parameter int NMAX = 384,
  parameter int CW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          card_tick,
  input  logic          card_rst,
  output logic          phase_hi,
  output logic          rst_edge,
  output logic [CW-1:0] pulse_cnt
);
  localparam logic [CW-1:0] CAP = CW'(NMAX);

  assign rst_edge = card_rst ^ phase_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_hi  <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      phase_hi <= card_rst;
      if (rst_edge)
        pulse_cnt <= '0;
      else if (card_tick && pulse_cnt != CAP)
        pulse_cnt <= pulse_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ead_judge.sv
module ead_judge
  import ead_pkg::*;
#(
  parameter int IGN  = 200,
  parameter int NMAX = 384,
  parameter int CW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_bit,
  input  logic          rst_edge,
  input  logic          phase_hi,
  input  logic [CW-1:0] pulse_cnt,
  output logic          armed,
  output logic          ea_pulse,
  output logic          ea_flag
);
  verdict_t verdict;

  always_comb verdict = ead_verdict(phase_hi, 32'(pulse_cnt), IGN, NMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b1;
      ea_pulse <= 1'b0;
      ea_flag  <= 1'b0;
    end else if (rst_edge) begin
      armed    <= 1'b1;
      ea_pulse <= 1'b0;
      ea_flag  <= 1'b0;
    end else begin
      ea_pulse <= 1'b0;
      if (start_bit && armed && verdict != V_IGNORE) begin
        armed <= 1'b0;
        if (verdict == V_EARLY) begin
          ea_pulse <= 1'b1;
          ea_flag  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/early_answer_detect.sv
module early_answer_detect #(
  parameter int IGN  = 200,
  parameter int NMAX = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_tick,
  input  logic card_rst,
  input  logic io_line,
  output logic ea_pulse,
  output logic ea_flag
);
  localparam int CW = $clog2(NMAX + 1);

  // named internal events, used by the bound checker
  logic          start_bit;
  logic          rst_edge;
  logic          phase_hi;
  logic          armed;
  logic [CW-1:0] pulse_cnt;

  ead_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (io_line),
    .line_fall (start_bit)
  );

  ead_phase_cnt #(.NMAX(NMAX), .CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .card_tick (card_tick),
    .card_rst  (card_rst),
    .phase_hi  (phase_hi),
    .rst_edge  (rst_edge),
    .pulse_cnt (pulse_cnt)
  );

  ead_judge #(.IGN(IGN), .NMAX(NMAX), .CW(CW)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_bit (start_bit),
    .rst_edge  (rst_edge),
    .phase_hi  (phase_hi),
    .pulse_cnt (pulse_cnt),
    .armed     (armed),
    .ea_pulse  (ea_pulse),
    .ea_flag   (ea_flag)
  );
endmodule

// File: rtl/ead_checker.sv
module ead_checker #(
  parameter int IGN  = 200,
  parameter int NMAX = 384,
  parameter int CW   = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_bit,
  input logic          rst_edge,
  input logic          phase_hi,
  input logic          armed,
  input logic [CW-1:0] pulse_cnt,
  input logic          ea_pulse,
  input logic          ea_flag
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !ea_pulse && !ea_flag);

  // R2
  ignore_keeps_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bit && !rst_edge && !phase_hi && armed && pulse_cnt < CW'(IGN))
      |=> (!ea_pulse && armed));

  // R3
  early_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_pulse |-> ($past(start_bit) && $past(pulse_cnt) < CW'(NMAX)));

  // R5
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CW'(NMAX));

  // R6
  pulse_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_pulse |-> (!armed && $past(armed)));

  // R7
  edge_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_edge |=> (armed && !ea_flag && pulse_cnt == '0));

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_pulse |=> !ea_pulse);

  // R8
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_pulse |-> ea_flag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ea_flag) && !$past(rst_edge)) |-> ea_flag);
endmodule

bind early_answer_detect ead_checker #(.IGN(IGN), .NMAX(NMAX), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_bit (start_bit),
  .rst_edge  (rst_edge),
  .phase_hi  (phase_hi),
  .armed     (armed),
  .pulse_cnt (pulse_cnt),
  .ea_pulse  (ea_pulse),
  .ea_flag   (ea_flag)
);

// File: tb/tb_early_answer_detect.sv
module tb_early_answer_detect;
  localparam int S_IGN = 6, S_NMAX = 12;     // small instance
  localparam int F_IGN = 200, F_NMAX = 384;  // default instance

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_tick = 1'b0;
  logic card_rst = 1'b0;
  logic io_line = 1'b1;
  logic p_s, f_s, p_f, f_f;
  logic es_flag, ef_flag;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  early_answer_detect #(.IGN(S_IGN), .NMAX(S_NMAX)) dut (
    .clk(clk), .rst_n(rst_n), .card_tick(card_tick), .card_rst(card_rst),
    .io_line(io_line), .ea_pulse(p_s), .ea_flag(f_s));

  early_answer_detect dut_full (
    .clk(clk), .rst_n(rst_n), .card_tick(card_tick), .card_rst(card_rst),
    .io_line(io_line), .ea_pulse(p_f), .ea_flag(f_f));

  // bench-side model: early when the count lies inside the phase window
  function automatic logic is_early(input logic ph, input int k, input int ign, input int nmax);
    int lo;
    lo = ph ? 0 : ign;
    return (k >= lo) && (k < nmax);
  endfunction

  // the first start bit is still pending only in the low-phase ignore period
  function automatic logic ignored(input logic ph, input int k, input int ign);
    return !ph && k < ign;
  endfunction

  function automatic string req_of(input logic ph, input int k, input int ign, input int nmax);
    if (k >= nmax) return "R5";
    if (ph)        return "R4";
    if (k < ign)   return "R2";
    return "R3";
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Make a fresh reset edge into phase ph. The counter is 0 after the returning negedge.
  task automatic enter_phase(input logic ph);
    card_rst = ~ph;
    repeat (2) @(negedge clk);
    card_rst = ph;
    @(negedge clk);
    es_flag = 1'b0;
    ef_flag = 1'b0;
    chk(f_s, 1'b0, "R7", "small flag after reset edge");
    chk(f_f, 1'b0, "R7", "full flag after reset edge");
  endtask

  task automatic ticks(input int n);
    card_tick = 1'b1;
    repeat (n) @(negedge clk);
    card_tick = 1'b0;
  endtask

  task automatic fall_check(input logic xs, input logic xf, input string rs, input string rf);
    io_line = 1'b0;
    repeat (2) @(negedge clk);
    chk(p_s, 1'b0, "R9", "small pulse before third edge");
    chk(p_f, 1'b0, "R9", "full pulse before third edge");
    @(negedge clk);
    chk(p_s, xs, rs, "small pulse");
    chk(p_f, xf, rf, "full pulse");
    es_flag = es_flag | xs;
    ef_flag = ef_flag | xf;
    @(negedge clk);
    chk(p_s, 1'b0, "R8", "small pulse width");
    chk(p_f, 1'b0, "R8", "full pulse width");
    chk(f_s, es_flag, "R8", "small flag");
    chk(f_f, ef_flag, "R8", "full flag");
  endtask

  task automatic rise_check();
    io_line = 1'b1;
    repeat (4) @(negedge clk);
    chk(p_s, 1'b0, "R9", "small no pulse on rise");
    chk(p_f, 1'b0, "R9", "full no pulse on rise");
  endtask

  task automatic trial(input logic ph, input int k);
    enter_phase(ph);
    ticks(k);
    fall_check(is_early(ph, k, S_IGN, S_NMAX), is_early(ph, k, F_IGN, F_NMAX),
               req_of(ph, k, S_IGN, S_NMAX), req_of(ph, k, F_IGN, F_NMAX));
    rise_check();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    es_flag = 1'b0;
    ef_flag = 1'b0;
    repeat (3) @(negedge clk);
    chk(p_s | f_s, 1'b0, "R1", "small outputs in reset");
    chk(p_f | f_f, 1'b0, "R1", "full outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(p_s | f_s, 1'b0, "R1", "small outputs after reset");
    chk(p_f | f_f, 1'b0, "R1", "full outputs after reset");

    // sweep both phases over every count up past saturation (R2 R3 R4 R5)
    for (int ph = 0; ph < 2; ph++)
      for (int k = 0; k <= 20; k++)
        trial(ph[0], k);

    // default instance boundaries (R3 R4 R5)
    trial(1'b0, F_IGN - 1);
    trial(1'b0, F_IGN);
    trial(1'b0, F_NMAX - 1);
    trial(1'b0, F_NMAX);
    trial(1'b1, F_NMAX - 1);
    trial(1'b1, F_NMAX);

    // R2: an ignored start bit leaves the detector armed
    enter_phase(1'b0);
    ticks(2);
    fall_check(1'b0, 1'b0, "R2", "R2");
    rise_check();
    ticks(6);
    fall_check(is_early(1'b0, 8, S_IGN, S_NMAX), 1'b0, "R2", "R2");
    rise_check();

    // R6: a second start bit after an early answer is ignored
    enter_phase(1'b0);
    ticks(S_IGN);
    fall_check(1'b1, 1'b0, "R6", "R6");
    rise_check();
    ticks(1);
    fall_check(1'b0, 1'b0, "R6", "R6");
    rise_check();

    // R6: after a late first start bit, a start bit never triggers again
    enter_phase(1'b1);
    ticks(S_NMAX);
    fall_check(1'b0, 1'b1, "R6", "R4");
    rise_check();
    fall_check(1'b0, 1'b0, "R6", "R6");
    rise_check();

    // R7: a flag set in the high phase clears on the next reset edge
    enter_phase(1'b1);
    fall_check(1'b1, 1'b1, "R4", "R4");
    rise_check();
    card_rst = 1'b0;
    @(negedge clk);
    chk(f_s, 1'b0, "R7", "small flag cleared by edge");
    chk(f_f, 1'b0, "R7", "full flag cleared by edge");
    chk(ignored(1'b0, 0, S_IGN), 1'b1, "R7", "model sanity");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule